// File: doc/BRIEF.md
# Engine Enable and Power-Switch Clamp Control Registers

This block is a slave register file holding three control registers. Together they let boot software enable a graphics engine and release its power gating by hand. A simple request/acknowledge register bus writes and reads the registers. Each implemented field drives a hardware control output directly.

The engine-enable register carries two fields:
- an engine enable, which drives the engine reset output low when set;
- a block-level gating enable.

The power-switch register and the thermal control register each hold a mask/override bit and a value bit. While the mask or override bit is set, the value bit replaces a default signal that comes from elsewhere in the chip. While it is clear, the default passes through unchanged. Software normally changes one field at a time by read-modify-write. The other fields must therefore read back exactly as they were written.

Top module: `eng_clamp_regs`

## Requirements
- R1: After the asynchronous reset `rst_ni`, every implemented field is 0. As a result, `eng_rst_o`=1, `gate_ctl_en_o`=0, `clamp_o` follows `clamp_dflt_i`, `pg_req_o` follows `boot_pg_i`, and `ack_o` and `rdata_o` are 0.
- R2: The engine register is at address 0x000200, and its bit 12 is the engine enable. `eng_rst_o` is the inverse of this bit and changes right after the clock edge that writes it.
- R3: Bit 27 of the engine register drives `gate_ctl_en_o` directly.
- R4: The switch register is at 0x10A78C, with bit 0 as the clamp mask and bit 1 as the clamp value. While the mask is 1, `clamp_o` equals the value bit. While the mask is 0, `clamp_o` equals `clamp_dflt_i`.
- R5: The thermal register is at 0x020004, with bit 30 as the override enable and bit 31 as the override value. While the override is 1, `pg_req_o` equals the value bit. While it is 0, `pg_req_o` equals `boot_pg_i`.
- R6: Every cycle with `req_i`=1 is acknowledged by `ack_o`=1 in the next cycle. `ack_o` is 0 after a cycle without a request.
- R7: A read returns the addressed register in `rdata_o` in the cycle of its acknowledge. Unimplemented bits read 0, and writes to them are dropped. `rdata_o` is 0 when no read is being acknowledged.
- R8: A read of any other address returns 0, and a write to it changes no register.
- R9: A write changes only the addressed register. Writing back a read value with one field altered leaves every other implemented field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | Access acknowledge, one cycle after request |
| rdata_o | output | DATA_W | Read data, valid with ack_o |
| clamp_dflt_i | input | 1 | Default clamp level when not masked |
| boot_pg_i | input | 1 | Boot-strap power-gate request |
| eng_rst_o | output | 1 | Engine reset, high while engine disabled |
| gate_ctl_en_o | output | 1 | Block-level gating controllers enable |
| clamp_o | output | 1 | Clamp to the power switch |
| pg_req_o | output | 1 | Power-gate request |

## Verification
On every cycle, the assertions check the following:
- the acknowledge timing;
- that a write to the engine register sets the reset and gating outputs in the following cycle;
- that forced clamp and override values appear at the outputs;
- that the clamp follows its default while unmasked;
- that unmapped reads return 0;
- that the gating enable holds when the engine register is not written.

Only the bench scenarios show the following:
- read-back of exact field positions, including the zeros of unimplemented bits;
- read-modify-write sequences that alter one field and keep the rest;
- the override muxes tracking their default inputs while those inputs toggle.

// File: rtl/eng_clamp_pkg.sv
package eng_clamp_pkg;
  localparam logic [31:0] ENG_ADDR  = 32'h0000_0200;
  localparam logic [31:0] CLMP_ADDR = 32'h0010_A78C;
  localparam logic [31:0] THRM_ADDR = 32'h0002_0004;

  localparam int unsigned ENG_EN_BIT   = 12;
  localparam int unsigned GATE_EN_BIT  = 27;
  localparam int unsigned CLMP_MSK_BIT = 0;
  localparam int unsigned CLMP_VAL_BIT = 1;
  localparam int unsigned OVR_EN_BIT   = 30;
  localparam int unsigned OVR_VAL_BIT  = 31;

  localparam int unsigned NUM_REGS = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ENG  = 2'd1,
    SEL_CLMP = 2'd2,
    SEL_THRM = 2'd3
  } reg_sel_e;

  function automatic logic [31:0] impl_mask(int idx);
    case (idx)
      0:       return (32'h1 << ENG_EN_BIT) | (32'h1 << GATE_EN_BIT);
      1:       return (32'h1 << CLMP_MSK_BIT) | (32'h1 << CLMP_VAL_BIT);
      default: return (32'h1 << OVR_EN_BIT) | (32'h1 << OVR_VAL_BIT);
    endcase
  endfunction

  function automatic reg_sel_e sel_of(int idx);
    case (idx)
      0:       return SEL_ENG;
      1:       return SEL_CLMP;
      default: return SEL_THRM;
    endcase
  endfunction
endpackage

// File: rtl/eng_clamp_decode.sv
module eng_clamp_decode
  import eng_clamp_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(ENG_ADDR))       sel_o = SEL_ENG;
    else if (addr_i == ADDR_W'(CLMP_ADDR)) sel_o = SEL_CLMP;
    else if (addr_i == ADDR_W'(THRM_ADDR)) sel_o = SEL_THRM;
    else                                   sel_o = SEL_NONE;
  end
endmodule

// File: rtl/eng_clamp_field_reg.sv
module eng_clamp_field_reg #(
  parameter int unsigned          DATA_W = 32,
  parameter logic [DATA_W-1:0]    IMPL   = '0,
  parameter logic [DATA_W-1:0]    RST    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  // Only implemented bits hold state; the rest stay 0.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST & IMPL;
    else if (we_i) q_o <= wdata_i & IMPL;
  end
endmodule

// File: rtl/eng_clamp_ovr_mux.sv
module eng_clamp_ovr_mux #(
  parameter int unsigned N = 1
) (
  input  logic [N-1:0] force_i,
  input  logic [N-1:0] val_i,
  input  logic [N-1:0] dflt_i,
  output logic [N-1:0] y_o
);
  for (genvar i = 0; i < N; i++) begin : g_mux
    assign y_o[i] = force_i[i] ? val_i[i] : dflt_i[i];
  end
endmodule

// File: rtl/eng_clamp_regs.sv
module eng_clamp_regs
  import eng_clamp_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              clamp_dflt_i,
  input  logic              boot_pg_i,
  output logic              eng_rst_o,
  output logic              gate_ctl_en_o,
  output logic              clamp_o,
  output logic              pg_req_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] reg_q [NUM_REGS];
  logic [DATA_W-1:0] rd_mux;
  logic [1:0]        mux_y;

  eng_clamp_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    eng_clamp_field_reg #(
      .DATA_W (DATA_W),
      .IMPL   (DATA_W'(impl_mask(g))),
      .RST    ('0)
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (req_i && we_i && (sel == sel_of(g))),
      .wdata_i (wdata_i),
      .q_o     (reg_q[g])
    );
  end

  always_comb begin
    case (sel)
      SEL_ENG:  rd_mux = reg_q[0];
      SEL_CLMP: rd_mux = reg_q[1];
      SEL_THRM: rd_mux = reg_q[2];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i;
      rdata_o <= (req_i && !we_i) ? rd_mux : '0;
    end
  end

  assign eng_rst_o     = ~reg_q[0][ENG_EN_BIT];
  assign gate_ctl_en_o = reg_q[0][GATE_EN_BIT];

  // bit 0: clamp, bit 1: power-gate request
  eng_clamp_ovr_mux #(.N(2)) u_mux (
    .force_i ({reg_q[2][OVR_EN_BIT],  reg_q[1][CLMP_MSK_BIT]}),
    .val_i   ({reg_q[2][OVR_VAL_BIT], reg_q[1][CLMP_VAL_BIT]}),
    .dflt_i  ({boot_pg_i,             clamp_dflt_i}),
    .y_o     (mux_y)
  );

  assign clamp_o  = mux_y[0];
  assign pg_req_o = mux_y[1];
endmodule

// File: rtl/eng_clamp_regs_chk.sv
module eng_clamp_regs_chk
  import eng_clamp_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ack_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              clamp_dflt_i,
  input logic              boot_pg_i,
  input logic              eng_rst_o,
  input logic              gate_ctl_en_o,
  input logic              clamp_o,
  input logic              pg_req_o
);
  logic wr_eng, wr_clmp, wr_thrm, rd_unmapped;
  assign wr_eng  = req_i && we_i && (addr_i == ADDR_W'(ENG_ADDR));
  assign wr_clmp = req_i && we_i && (addr_i == ADDR_W'(CLMP_ADDR));
  assign wr_thrm = req_i && we_i && (addr_i == ADDR_W'(THRM_ADDR));
  assign rd_unmapped = req_i && !we_i && (addr_i != ADDR_W'(ENG_ADDR)) &&
                       (addr_i != ADDR_W'(CLMP_ADDR)) && (addr_i != ADDR_W'(THRM_ADDR));

  AST_RST_OUTPUTS: assert property (@(posedge clk_i)
    !rst_ni |-> (eng_rst_o && !gate_ctl_en_o && !ack_o)); // R1
  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o); // R6
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o); // R6
  AST_ENG_RST_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_eng |=> (eng_rst_o == !$past(wdata_i[ENG_EN_BIT]))); // R2
  AST_GATE_EN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_eng |=> (gate_ctl_en_o == $past(wdata_i[GATE_EN_BIT]))); // R3
  AST_CLAMP_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clmp && wdata_i[CLMP_MSK_BIT]) |=> (clamp_o == $past(wdata_i[CLMP_VAL_BIT]))); // R4
  AST_CLAMP_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clmp && !wdata_i[CLMP_MSK_BIT]) |=> (clamp_o == clamp_dflt_i)); // R4
  AST_PG_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_thrm && wdata_i[OVR_EN_BIT]) |=> (pg_req_o == $past(wdata_i[OVR_VAL_BIT]))); // R5
  AST_PG_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_thrm && !wdata_i[OVR_EN_BIT]) |=> (pg_req_o == boot_pg_i)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unmapped |=> (rdata_o == '0)); // R8
  AST_WRITE_NO_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (rdata_o == '0)); // R7
  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_eng |=> $stable(gate_ctl_en_o)); // R9
endmodule

bind eng_clamp_regs eng_clamp_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/eng_clamp_regs_bench.sv
`timescale 1ns/1ps
module eng_clamp_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ack_o;
  logic [31:0] rdata_o;
  logic        clamp_dflt_i = 1'b0, boot_pg_i = 1'b1;
  logic        eng_rst_o, gate_ctl_en_o, clamp_o, pg_req_o;

  int checks = 0, failures = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #5 clk_i = ~clk_i;

  eng_clamp_regs u_eng_clamp_regs (.*);

  // behavioural reference
  bit m_en, m_gate, m_msk, m_cval, m_oen, m_oval, m_ack;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(logic [23:0] a);
    case (a)
      24'h000200: return {4'b0, m_gate, 14'b0, m_en, 12'b0};
      24'h10A78C: return {30'b0, m_cval, m_msk};
      24'h020004: return {m_oval, m_oen, 30'b0};
      default:    return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_en, m_gate, m_msk, m_cval, m_oen, m_oval, m_ack} <= '0;
      m_rdata <= '0;
    end else begin
      m_ack   <= req_i;
      m_rdata <= (req_i && !we_i) ? m_read(addr_i) : 32'h0;
      if (req_i && we_i) begin
        case (addr_i)
          24'h000200: begin m_en <= wdata_i[12]; m_gate <= wdata_i[27]; end
          24'h10A78C: begin m_msk <= wdata_i[0]; m_cval <= wdata_i[1]; end
          24'h020004: begin m_oen <= wdata_i[30]; m_oval <= wdata_i[31]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_en) begin
      chk("R2 eng_rst_o", 32'(eng_rst_o), 32'(!m_en));
      chk("R3 gate_ctl_en_o", 32'(gate_ctl_en_o), 32'(m_gate));
      chk("R4 clamp_o", 32'(clamp_o), 32'(m_msk ? m_cval : clamp_dflt_i));
      chk("R5 pg_req_o", 32'(pg_req_o), 32'(m_oen ? m_oval : boot_pg_i));
      chk("R6 ack_o", 32'(ack_o), 32'(m_ack));
      chk("R7 rdata_o", rdata_o, m_rdata);
    end
  end

  task automatic bus_wr(input logic [23:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic [23:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk_i); #1;
    req_i = 1'b0;
    @(negedge clk_i); d = rdata_o;
    @(posedge clk_i); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk_i); #1; end
  endtask

  initial begin
    logic [31:0] v;
    #2 rst_ni = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 eng_rst_o", 32'(eng_rst_o), 32'd1);
    chk("R1 gate_ctl_en_o", 32'(gate_ctl_en_o), 32'd0);
    chk("R1 clamp_o", 32'(clamp_o), 32'(clamp_dflt_i));
    chk("R1 pg_req_o", 32'(pg_req_o), 32'd1);
    chk("R1 ack_o", 32'(ack_o), 32'd0);
    cmp_en = 1'b1;
    @(posedge clk_i); #1;

    // R2/R3/R7 full write to engine register
    bus_wr(24'h000200, 32'hFFFF_FFFF);
    chk("R2 engine out of reset", 32'(eng_rst_o), 32'd0);
    bus_rd(24'h000200, v);
    chk("R7 engine readback", v, 32'h0800_1000);

    // R9 read-modify-write: clear engine enable, keep gating
    bus_rd(24'h000200, v);
    bus_wr(24'h000200, v & ~32'h0000_1000);
    bus_rd(24'h000200, v);
    chk("R9 rmw keeps gate bit", v, 32'h0800_0000);
    chk("R3 gate still on", 32'(gate_ctl_en_o), 32'd1);
    chk("R2 reset back on", 32'(eng_rst_o), 32'd1);

    // R4 clamp mask/value
    bus_wr(24'h10A78C, 32'h0000_0002);
    clamp_dflt_i = 1'b1; idle(1);
    chk("R4 unmasked follows default", 32'(clamp_o), 32'd1);
    clamp_dflt_i = 1'b0; idle(1);
    chk("R4 unmasked follows default low", 32'(clamp_o), 32'd0);
    bus_rd(24'h10A78C, v);
    bus_wr(24'h10A78C, v | 32'h1);
    chk("R4 masked gives value", 32'(clamp_o), 32'd1);
    bus_rd(24'h10A78C, v);
    bus_wr(24'h10A78C, v & ~32'h2);
    clamp_dflt_i = 1'b1; idle(1);
    chk("R4 masked ignores default", 32'(clamp_o), 32'd0);
    bus_rd(24'h10A78C, v);
    chk("R9 clamp rmw keeps mask", v, 32'h0000_0001);
    bus_wr(24'h10A78C, 32'h0000_0000);
    chk("R4 release to default", 32'(clamp_o), 32'd1);

    // R5 override
    bus_wr(24'h020004, 32'h4000_0000);
    chk("R5 override forces 0", 32'(pg_req_o), 32'd0);
    bus_rd(24'h020004, v);
    bus_wr(24'h020004, v | 32'h8000_0000);
    bus_rd(24'h020004, v);
    chk("R9 therm rmw keeps enable", v, 32'hC000_0000);
    boot_pg_i = 1'b0; idle(1);
    chk("R5 override ignores boot input", 32'(pg_req_o), 32'd1);
    bus_wr(24'h020004, 32'h8000_0000);
    chk("R5 override off follows boot", 32'(pg_req_o), 32'd0);
    boot_pg_i = 1'b1; idle(1);
    chk("R5 follows boot high", 32'(pg_req_o), 32'd1);

    // R8 unmapped
    bus_wr(24'h000204, 32'hFFFF_FFFF);
    bus_wr(24'h10A788, 32'hFFFF_FFFF);
    bus_rd(24'h000204, v);
    chk("R8 unmapped reads 0", v, 32'h0);
    bus_rd(24'h000200, v);
    chk("R8 engine untouched", v, 32'h0800_0000);
    bus_rd(24'h10A78C, v);
    chk("R8 clamp untouched", v, 32'h0);
    bus_rd(24'h020004, v);
    chk("R8 therm untouched", v, 32'h8000_0000);

    // R6 back-to-back requests
    req_i = 1'b1; we_i = 1'b0; addr_i = 24'h020004;
    idle(3);
    req_i = 1'b0;
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule